// File: doc/BRIEF.md
# Five-State Multicycle Byte Processor

This block is a small 8-bit processor that executes one instruction at a time. Each instruction passes through a fixed control sequence of five stages: instruction fetch, decode with register read, ALU operation, memory access and register write-back. Every stage is visited even when it has no work for the current instruction. There is no overlap between instructions. The datapath holds four 8-bit general-purpose registers, a program counter, a memory address register and the latches between stages.

A single synchronous read port serves both instruction and data reads. The block drives an address and a read strobe. The memory returns the addressed byte on the read-data bus one clock later. An instruction is two bytes long. The first byte carries the opcode in bits 7:6, the destination register index in bits 5:4 and the source register index in bits 3:2. Bits 1:0 are ignored. The second byte is an immediate value or a memory address.

Opcode 00 loads the immediate into the destination. Opcode 01 loads the destination from memory at the address byte. Opcode 10 adds the source register into the destination. Opcode 11 stops the processor. The halt flag, program counter, register contents and current stage are visible at the ports for debug.

Top module: `quint_cpu`

## Requirements
- R1: The stage output uses the codes fetch=0, decode=1, ALU=2, memory=3, write-back=4 and halted=5. Fetch occupies two cycles and every other stage one cycle. A non-halt instruction therefore runs fetch, fetch, decode, ALU, memory, write-back and then returns to fetch, six cycles in all.
- R2: While rst_ni is low, the registers and program counter read zero, the stage is fetch and the halt flag is low.
- R3: In the first fetch cycle the block reads address pc. In the second it reads address pc+1, with mem_re_o high in both. The program counter advances by 2, modulo 256, at the end of fetch and stays unchanged at every other time.
- R4: Opcode 00 writes the second byte into register bits 5:4 of the first byte.
- R5: Opcode 01 reads memory at the address in the second byte during the memory stage, with mem_re_o high and mem_addr_o equal to that byte. It writes the returned byte into the destination at the end of write-back.
- R6: Opcode 10 writes (dst + src) mod 256 into the destination and leaves every other register unchanged. When the destination and source are the same register, the effect is doubling.
- R7: For opcodes 00 and 10, mem_re_o stays low during the memory stage.
- R8: Opcode 11 leaves decode for the halted stage. halt_o then stays high and mem_re_o stays low until reset, and the program counter and registers stay frozen.
- R9: The register file changes only at the end of the write-back stage, and only in the destination register. Bits 1:0 of the first byte have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 8 | Memory read address |
| mem_re_o | output | 1 | Memory read strobe |
| mem_rdata_i | input | 8 | Read data, valid one cycle after the address |
| halt_o | output | 1 | Halted flag |
| pc_o | output | 8 | Program counter |
| regs_o | output | 32 | Register contents, register i in bits 8i+7:8i |
| stage_o | output | 3 | Current stage code |

## Verification
The bench builds the block with its default 8-bit word and four registers. At that size, every destination and source pairing of the add, including self-addition, can be swept with operand sets that cross the wrap at 256. Memory loads are run against addresses spread over the full 256-byte space, including addresses that hold program bytes. A program filling the entire memory exercises program counter wrap-around. Each stage of every instruction is checked for its code, its address and its strobe.

// File: rtl/quint_pkg.sv
package quint_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned NREG   = 4;
  localparam int unsigned RIDX_W = $clog2(NREG);
  localparam int unsigned OP_W   = 2;
  localparam int unsigned STG_W  = 3;

  typedef enum logic [OP_W-1:0] {
    OP_LDI  = 2'b00,
    OP_LDM  = 2'b01,
    OP_ADD  = 2'b10,
    OP_STOP = 2'b11
  } op_e;

  typedef enum logic [STG_W-1:0] {
    STG_FETCH = 3'd0,
    STG_DEC   = 3'd1,
    STG_ALU   = 3'd2,
    STG_MEM   = 3'd3,
    STG_WB    = 3'd4,
    STG_STOP  = 3'd5
  } stage_e;

  typedef struct packed {
    op_e               op;
    logic [RIDX_W-1:0] dst;
    logic [RIDX_W-1:0] src;
    logic [DATA_W-OP_W-2*RIDX_W-1:0] pad;
  } instr_t;
endpackage

// File: rtl/quint_regfile.sv
module quint_regfile
  import quint_pkg::*;
#(
  parameter int unsigned N  = NREG,
  parameter int unsigned W  = DATA_W,
  localparam int unsigned AW = $clog2(N)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [AW-1:0]  waddr_i,
  input  logic [W-1:0]   wdata_i,
  input  logic [AW-1:0]  raddr_a_i,
  input  logic [AW-1:0]  raddr_b_i,
  output logic [W-1:0]   rdata_a_o,
  output logic [W-1:0]   rdata_b_o,
  output logic [N*W-1:0] flat_o
);
  logic [W-1:0] mem_q [N];

  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               mem_q[g] <= '0;
      else if (we_i && waddr_i == AW'(g))        mem_q[g] <= wdata_i;
    end
    assign flat_o[g*W +: W] = mem_q[g];
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];

  // R9: no write strobe, no change anywhere in the file
  p_quiet_file_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(flat_o));
endmodule

// File: rtl/quint_alu.sv
module quint_alu
  import quint_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  op_e          op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] imm_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_ADD:  res_o = a_i + b_i;  // carry dropped
      default: res_o = imm_i;
    endcase
  end
endmodule

// File: rtl/quint_ctrl.sv
module quint_ctrl
  import quint_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  op_e    op_i,
  output stage_e stage_o,
  output logic   fetch_hi_o,
  output logic   fetch_end_o,
  output logic   dec_o,
  output logic   alu_o,
  output logic   mem_rd_o,
  output logic   wb_o,
  output logic   stop_o
);
  stage_e stage_q, stage_d;
  logic   hi_q, hi_d;

  always_comb begin
    stage_d = stage_q;
    hi_d    = 1'b0;
    unique case (stage_q)
      STG_FETCH: begin
        hi_d = ~hi_q;
        if (hi_q) stage_d = STG_DEC;
      end
      STG_DEC:  stage_d = (op_i == OP_STOP) ? STG_STOP : STG_ALU;
      STG_ALU:  stage_d = STG_MEM;
      STG_MEM:  stage_d = STG_WB;
      STG_WB:   stage_d = STG_FETCH;
      default:  stage_d = STG_STOP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= STG_FETCH;
      hi_q    <= 1'b0;
    end else begin
      stage_q <= stage_d;
      hi_q    <= hi_d;
    end
  end

  assign stage_o     = stage_q;
  assign fetch_hi_o  = hi_q;
  assign fetch_end_o = (stage_q == STG_FETCH) && hi_q;
  assign dec_o       = (stage_q == STG_DEC);
  assign alu_o       = (stage_q == STG_ALU);
  assign mem_rd_o    = (stage_q == STG_MEM) && (op_i == OP_LDM);
  assign wb_o        = (stage_q == STG_WB);
  assign stop_o      = (stage_q == STG_STOP);

  p_alu_to_mem_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_q == STG_ALU |=> stage_q == STG_MEM);
  p_mem_to_wb_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_q == STG_MEM |=> stage_q == STG_WB);
  p_wb_to_fetch_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_q == STG_WB |=> (stage_q == STG_FETCH && !hi_q));
  p_fetch_two_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_q == STG_FETCH && !hi_q) |=> (stage_q == STG_FETCH && hi_q));
  p_stop_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_q == STG_STOP |=> stage_q == STG_STOP);
endmodule

// File: rtl/quint_cpu.sv
module quint_cpu
  import quint_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  output logic [DATA_W-1:0]    mem_addr_o,
  output logic                 mem_re_o,
  input  logic [DATA_W-1:0]    mem_rdata_i,
  output logic                 halt_o,
  output logic [DATA_W-1:0]    pc_o,
  output logic [NREG*DATA_W-1:0] regs_o,
  output logic [STG_W-1:0]     stage_o
);
  localparam logic [DATA_W-1:0] PC_STEP = DATA_W'(2);

  logic [DATA_W-1:0] pc_q, mar_q, imm_q, opa_q, opb_q, res_q;
  instr_t            ir_q;
  stage_e            stage;
  logic fetch_hi, fetch_end, in_dec, in_alu, mem_rd, in_wb, stopped;
  logic [DATA_W-1:0] rf_a, rf_b, alu_res, wdata;

  quint_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .op_i        (ir_q.op),
    .stage_o     (stage),
    .fetch_hi_o  (fetch_hi),
    .fetch_end_o (fetch_end),
    .dec_o       (in_dec),
    .alu_o       (in_alu),
    .mem_rd_o    (mem_rd),
    .wb_o        (in_wb),
    .stop_o      (stopped)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      ir_q  <= '0;
      imm_q <= '0;
      opa_q <= '0;
      opb_q <= '0;
      res_q <= '0;
      mar_q <= '0;
    end else begin
      if (fetch_end) begin
        ir_q <= instr_t'(mem_rdata_i);
        pc_q <= pc_q + PC_STEP;
      end
      if (in_dec) begin
        imm_q <= mem_rdata_i;  // second byte lands here
        opa_q <= rf_a;
        opb_q <= rf_b;
      end
      if (in_alu) begin
        res_q <= alu_res;
        mar_q <= imm_q;
      end
    end
  end

  quint_regfile u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (in_wb),
    .waddr_i   (ir_q.dst),
    .wdata_i   (wdata),
    .raddr_a_i (ir_q.dst),
    .raddr_b_i (ir_q.src),
    .rdata_a_o (rf_a),
    .rdata_b_o (rf_b),
    .flat_o    (regs_o)
  );

  quint_alu u_alu (
    .op_i  (ir_q.op),
    .a_i   (opa_q),
    .b_i   (opb_q),
    .imm_i (imm_q),
    .res_o (alu_res)
  );

  assign wdata = (ir_q.op == OP_LDM) ? mem_rdata_i : res_q;

  always_comb begin
    if (stage == STG_FETCH) mem_addr_o = pc_q + DATA_W'(fetch_hi);
    else                    mem_addr_o = mar_q;
  end
  assign mem_re_o = (stage == STG_FETCH) || mem_rd;
  assign halt_o   = stopped;
  assign pc_o     = pc_q;
  assign stage_o  = stage;

  p_pc_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_end |=> pc_q == $past(pc_q) + PC_STEP);
  p_pc_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_end |=> $stable(pc_q));
  p_mem_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage == STG_MEM && ir_q.op != OP_LDM) |-> !mem_re_o);
  p_mem_addr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage == STG_MEM && mem_re_o) |-> mem_addr_o == $past(imm_q));
  p_halt_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> (halt_o && !mem_re_o && $stable(regs_o)));
endmodule

// File: tb/quint_cpu_test.sv
module quint_cpu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  mem_addr, mem_rdata, pc;
  logic        mem_re, halt;
  logic [31:0] regs;
  logic [2:0]  stage;
  logic [7:0]  mem [256];
  int          n_chk = 0, n_fail = 0, cyc = 0;

  always #2.5 clk = ~clk;

  quint_cpu uut (
    .clk_i(clk), .rst_ni(rst_n), .mem_addr_o(mem_addr), .mem_re_o(mem_re),
    .mem_rdata_i(mem_rdata), .halt_o(halt), .pc_o(pc), .regs_o(regs), .stage_o(stage)
  );

  always_ff @(posedge clk) mem_rdata <= mem[mem_addr];

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_fail++;
        $display("FAIL watchdog act=%0d exp<=150000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] enc(input int op, input int d, input int s, input int pad);
    return {2'(op), 2'(d), 2'(s), 2'(pad)};
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic fill_stop();
    for (int a = 0; a < 256; a++) mem[a] = 8'hC0;
  endtask

  // Runs the program in mem from reset, checking every stage against an ISA model.
  task automatic run_prog(input int max_instr);
    logic [7:0]  epc = 8'h00;
    logic [31:0] m = 32'h0;
    logic [7:0]  b0, b1, sum;
    int op, d, s;
    rst_n = 1'b0;
    repeat (3) step();
    chk(regs == 0 && pc == 0 && !halt && stage == 0, "R2 reset", {regs[23:0], pc}, 0);
    rst_n = 1'b1;
    for (int i = 0; i < max_instr; i++) begin
      b0 = mem[epc];
      b1 = mem[8'(epc + 8'd1)];
      op = int'(b0[7:6]); d = int'(b0[5:4]); s = int'(b0[3:2]);
      chk(stage == 0 && mem_addr == epc && mem_re, "R3 fetch lo", {stage, mem_addr}, {3'd0, epc});
      step();
      chk(stage == 0 && mem_addr == 8'(epc + 8'd1) && mem_re, "R3 fetch hi", {stage, mem_addr}, {3'd0, 8'(epc + 8'd1)});
      step();
      epc = epc + 8'd2;
      chk(stage == 1 && pc == epc, "R1 R3 decode", {stage, pc}, {3'd1, epc});
      step();
      if (op == 3) begin
        chk(stage == 5 && halt, "R8 halted", {halt, stage}, {1'b1, 3'd5});
        repeat (5) step();
        chk(halt && !mem_re && pc == epc && regs == m, "R8 frozen", regs, m);
        return;
      end
      chk(stage == 2 && regs == m, "R1 R9 alu", regs, m);
      step();
      chk(stage == 3, "R1 mem stage", stage, 3);
      if (op == 1) chk(mem_re && mem_addr == b1, "R5 data read", {mem_re, mem_addr}, {1'b1, b1});
      else         chk(!mem_re, "R7 no read", mem_re, 0);
      step();
      chk(stage == 4 && regs == m, "R1 R9 write-back", regs, m);
      step();
      sum = m[d*8 +: 8] + m[s*8 +: 8];
      case (op)
        0: m[d*8 +: 8] = b1;
        1: m[d*8 +: 8] = mem[b1];
        default: m[d*8 +: 8] = sum;
      endcase
      chk(regs == m, op == 0 ? "R4 load imm" : op == 1 ? "R5 load mem" : "R6 add", regs, m);
    end
  endtask

  initial begin
    logic [7:0] v [4];
    logic [7:0] a;
    @(negedge clk);

    // R8: immediate stop at address 0
    fill_stop();
    run_prog(4);

    // R6, R9: every dst/src pair, including self-add, operands crossing 256
    for (int d = 0; d < 4; d++)
      for (int s = 0; s < 4; s++)
        for (int k = 0; k < 6; k++) begin
          fill_stop();
          for (int r = 0; r < 4; r++) begin
            v[r] = 8'((k * 73 + r * 59 + d * 17 + s * 5 + ((k & 1) * 200)) & 255);
            mem[2*r]     = enc(0, r, (r + k) & 3, k & 3);  // pad bits vary (R9)
            mem[2*r + 1] = v[r];
          end
          mem[8] = enc(2, d, s, 3 - (k & 3));
          mem[9] = 8'h5A;
          mem[10] = enc(3, 0, 0, 0);
          run_prog(8);
        end

    // R5: loads over the address space, including program bytes
    for (int j = 0; j < 16; j++) begin
      fill_stop();
      a = 8'(j * 17 + 3);
      for (int q = 0; q < 256; q++) if (q >= 16) mem[q] = 8'((q * 29 + j) & 255) | 8'h01;
      if (a >= 16) mem[a] = 8'(255 - j);
      mem[0] = enc(1, j & 3, 0, 0);      mem[1] = a;
      mem[2] = enc(1, (j + 1) & 3, 0, 1); mem[3] = 8'hFF;
      mem[4] = enc(1, (j + 2) & 3, 0, 2); mem[5] = 8'h00;
      mem[6] = enc(0, 3, 0, 0);          mem[7] = 8'(j * 11);
      mem[8] = enc(2, 3, j & 3, 0);      mem[9] = 8'h00;
      mem[10] = enc(3, 0, 0, 0);         mem[11] = 8'h00;
      mem[12] = enc(1, 3, 0, 0);         mem[13] = a;
      mem[10] = enc(1, 2, 0, 0);         mem[11] = 8'h0C;
      mem[14] = enc(3, 0, 0, 0);         mem[15] = 8'h00;
      run_prog(10);
    end

    // R3, R4: memory full of loads, program counter wraps past 255
    for (int q = 0; q < 128; q++) begin
      mem[2*q]     = enc(0, q & 3, 3, 0);
      mem[2*q + 1] = 8'(q * 7 + 1);
    end
    run_prog(132);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule